// File: doc/BRIEF.md
# Watchdog and Manual Reset Generator

This block drives an active-low processor reset from two sources. The first is a manual-reset pin: reset is held while that pin is low and lasts a fixed stretch after the pin returns high. The second is a watchdog that watches an activity line. Each rising or falling transition on that line restarts the watchdog timer. If the line makes no transition for a full timeout window, the block fires a reset pulse of fixed length. The timer stays cleared while reset is active. A line that stays stuck therefore produces pulses at a steady rate. The block does not hold reset asserted for good.

A third input, used while the system runs from backup supply, forces reset low. It also blocks both sources and keeps the timers cleared. Both asynchronous pins pass through a two-flop synchronizer. Activity is detected by comparing the synchronized level with its value one clock earlier. The timeout window and the pulse length are parameters counted in clock cycles. The reset output comes straight from a flop.

Top module: `supv_reset_gen`

Cycle counts below are numbered from the clock edge after an input change: edge 1 is the first rising clock edge after the change. T is `TIMEOUT_CYC` and P is `PULSE_CYC`.

## Requirements
- R1: While `rst_ni` is low, and after it is released with no other cause active, `rst_no` reads 1.
- R2: A low level on `mr_ni` drives `rst_no` to 0 at edge 3 after `mr_ni` falls.
- R3: After `mr_ni` returns high, `rst_no` stays 0 and rises at edge P+2. A low phase of L cycles therefore gives L+P-1 low cycles on `rst_no`.
- R4: Either transition on `wdi_i` restarts the watchdog. When consecutive transitions are at most T cycles apart, no reset occurs. This includes a one-cycle pulse, which is two transitions, and a transition that lands in the same cycle as expiry.
- R5: If `wdi_i` makes no transition for more than T cycles, `rst_no` falls at edge T+3 after the last transition.
- R6: A watchdog reset pulse keeps `rst_no` at 0 for exactly P cycles. No reset low phase is ever shorter than P cycles.
- R7: The watchdog timer is held at zero while reset is active. With `wdi_i` stuck, `rst_no` alternates between P low cycles and T high cycles.
- R8: If `mr_ni` goes low during a watchdog pulse, reset lasts until edge P+2 after `mr_ni` returns high.
- R9: While `ignore_i` is 1, `rst_no` is 0 from the next edge onwards. `mr_ni` and `wdi_i` have no effect while `ignore_i` is 1, and the timers stay cleared. After `ignore_i` falls, `rst_no` rises at edge P. With `wdi_i` stuck, the next watchdog pulse follows T cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| wdi_i | input | 1 | Activity line watched by the watchdog (asynchronous) |
| mr_ni | input | 1 | Manual reset request, active low (asynchronous) |
| ignore_i | input | 1 | Backup-mode force: asserts reset and masks both inputs |
| rst_no | output | 1 | Registered active-low reset to the processor |

## Verification
Some properties are checked on every cycle:
- `ignore_i` and a low synchronized manual level each drive reset on the next edge.
- A watchdog expiry always produces a low output.
- The watchdog count stays cleared while reset is active and never reaches the timeout value.
- No low phase on the output ends before P cycles.

Other behaviour depends on the exact position of edges, which only the bench scenarios can show:
- the T+3 expiry point found by sweeping the transition gap across the timeout boundary;
- the P+2 release after a manual reset of each width;
- the extension of a watchdog pulse by a manual request;
- the fixed P-low, T-high cadence of a stuck line;
- the release sequence after `ignore_i` falls.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

  // Request to the reset stretcher: hold keeps reset loaded, trig starts one pulse
  typedef struct packed {
    logic hold;
    logic trig;
  } rst_req_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/supv_edge.sv
module supv_edge #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic any_edge_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  // Rising and falling both count as activity
  assign any_edge_o = lvl_i ^ prev_q;

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int TIMEOUT_CYC = 40,
  localparam int CntW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  output logic            fire_o,
  output logic [CntW-1:0] cnt_o
);

  localparam logic [CntW-1:0] Last = CntW'(TIMEOUT_CYC - 1);

  logic [CntW-1:0] cnt_q, cnt_d;

  // Clear wins over expiry in the same cycle
  assign fire_o = !clear_i && (cnt_q == Last);

  always_comb begin
    if (clear_i || fire_o) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_reset_pkg::*;
#(
  parameter int PULSE_CYC = 12,
  localparam int CntW = $clog2(PULSE_CYC + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rst_req_t req_i,
  output logic     active_o,
  output logic     rst_no
);

  localparam logic [CntW-1:0] Load = CntW'(PULSE_CYC);

  logic [CntW-1:0] cnt_q, cnt_d;
  logic            rst_n_q;

  always_comb begin
    if (req_i.hold || req_i.trig) cnt_d = Load;
    else if (cnt_q != '0)         cnt_d = cnt_q - 1'b1;
    else                          cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rst_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      rst_n_q <= (cnt_d == '0);
    end
  end

  assign active_o = (cnt_q != '0);
  assign rst_no   = rst_n_q;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_reset_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40,
  parameter int PULSE_CYC   = 12,
  parameter int SYNC_STAGES = 2,
  localparam int WdW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_i,
  input  logic mr_ni,
  input  logic ignore_i,
  output logic rst_no
);

  logic           wdi_lvl, wdi_edge;
  logic           mr_lvl;
  logic           rst_active;
  logic           wd_clear, wd_fire;
  logic [WdW-1:0] wd_cnt;
  rst_req_t       req;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_wdi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdi_i),
    .q_o   (wdi_lvl)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_mr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mr_ni),
    .q_o   (mr_lvl)
  );

  supv_edge #(.RST_VAL(1'b0)) i_edge_wdi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (wdi_lvl),
    .any_edge_o(wdi_edge)
  );

  // Backup mode forces reset; a manual request is only seen outside it
  assign req.hold = ignore_i || !mr_lvl;
  assign req.trig = wd_fire;

  // Timer held clear on activity, on any reset cause and in backup mode
  assign wd_clear = (wdi_edge && !ignore_i) || req.hold || rst_active;

  supv_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(wd_clear),
    .fire_o (wd_fire),
    .cnt_o  (wd_cnt)
  );

  supv_stretch #(.PULSE_CYC(PULSE_CYC)) i_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .active_o(rst_active),
    .rst_no  (rst_no)
  );

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int TIMEOUT_CYC = 40,
  parameter int PULSE_CYC   = 12,
  parameter int WdW         = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ignore_i,
  input logic           mr_lvl,
  input logic           rst_active,
  input logic           wd_fire,
  input logic [WdW-1:0] wd_cnt,
  input logic           rst_no
);

  logic [15:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_run_q <= '0;
    else if (rst_no)          low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  // R9
  ignore_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignore_i |=> !rst_no);

  // R2
  mr_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_lvl |=> !rst_no);

  // R5
  fire_asserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |=> !rst_no);

  // R7
  timer_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active |=> (wd_cnt == '0));

  // R4
  timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(wd_cnt) < TIMEOUT_CYC);

  // R6
  min_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (32'(low_run_q) >= PULSE_CYC));

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .PULSE_CYC  (PULSE_CYC),
  .WdW        (WdW)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ignore_i  (ignore_i),
  .mr_lvl    (mr_lvl),
  .rst_active(rst_active),
  .wd_fire   (wd_fire),
  .wd_cnt    (wd_cnt),
  .rst_no    (rst_no)
);

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;

  localparam int T = 40;
  localparam int P = 12;

  logic clk_i    = 1'b0;
  logic rst_ni   = 1'b0;
  logic wdi_i    = 1'b0;
  logic mr_ni    = 1'b1;
  logic ignore_i = 1'b0;
  logic rst_no;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  supv_reset_gen #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .SYNC_STAGES(2)) i_supv_reset_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wdi_i   (wdi_i),
    .mr_ni   (mr_ni),
    .ignore_i(ignore_i),
    .rst_no  (rst_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // Fresh activity, then wait out any pulse in flight
  task automatic settle();
    tick();
    wdi_i = ~wdi_i;
    repeat (P + 6) tick();
  endtask

  // Sample after each edge until rst_no equals val; returns index or 0
  task automatic wait_for(input logic val, input int limit, output int idx);
    idx = 0;
    for (int i = 1; i <= limit; i++) begin
      tick();
      if (rst_no == val) begin
        idx = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows, first, last, idx, run;

    // R1: reset state
    repeat (3) tick();
    chk(rst_no == 1'b1, "R1 during reset", rst_no, 1);
    rst_ni = 1'b1;
    repeat (5) tick();
    chk(rst_no == 1'b1, "R1 after release", rst_no, 1);

    // R4/R5: sweep transition gap across the timeout boundary
    for (int g = 1; g <= T + 2; g++) begin
      settle();
      wdi_i = ~wdi_i;
      lows = 0;
      first = 0;
      for (int i = 1; i <= g + 4; i++) begin
        tick();
        if (!rst_no) begin
          lows++;
          if (first == 0) first = i;
        end
        if (i == g) wdi_i = ~wdi_i;
      end
      if (g <= T) chk(lows == 0, "R4 gap within timeout", lows, 0);
      else        chk(first == T + 3, "R5 expiry point", first, T + 3);
    end

    // R4: one-cycle pulse counts as activity
    settle();
    wdi_i = ~wdi_i;
    repeat (T - 6) tick();
    wdi_i = ~wdi_i;
    tick();
    wdi_i = ~wdi_i;
    lows = 0;
    for (int i = 1; i <= T - 2; i++) begin
      tick();
      if (!rst_no) lows++;
    end
    chk(lows == 0, "R4 short pulse", lows, 0);

    // R5/R6/R7: stuck line gives steady cadence
    settle();
    wdi_i = ~wdi_i;
    wait_for(1'b0, T + 10, idx);
    chk(idx == T + 3, "R5 stuck first expiry", idx, T + 3);
    for (int k = 0; k < 3; k++) begin
      wait_for(1'b1, 4 * P, idx);
      chk(idx == P, "R6 pulse length", idx, P);
      wait_for(1'b0, 4 * T, idx);
      chk(idx == T, "R7 high interval", idx, T);
    end

    // R2/R3: manual reset width sweep
    for (int l = 1; l <= 8; l++) begin
      settle();
      mr_ni = 1'b0;
      lows = 0;
      first = 0;
      last = 0;
      for (int i = 1; i <= l + P + 6; i++) begin
        tick();
        if (!rst_no) begin
          lows++;
          if (first == 0) first = i;
          last = i;
        end
        if (i == l) mr_ni = 1'b1;
      end
      chk(first == 3, "R2 assert latency", first, 3);
      chk(lows == l + P - 1, "R3 low length", lows, l + P - 1);
      chk(last == l + P + 1, "R3 release point", last, l + P + 1);
    end

    // R8: manual request during a watchdog pulse extends it
    settle();
    wdi_i = ~wdi_i;
    wait_for(1'b0, T + 10, idx);
    repeat (3) tick();
    mr_ni = 1'b0;
    repeat (4) tick();
    mr_ni = 1'b1;
    wait_for(1'b1, 4 * P, idx);
    chk(idx == P + 2, "R8 extended release", idx, P + 2);

    // R9: backup force masks inputs
    settle();
    ignore_i = 1'b1;
    tick();
    chk(rst_no == 1'b0, "R9 force latency", rst_no, 0);
    run = 0;
    for (int i = 2; i <= 14; i++) begin
      if (i == 3) mr_ni = 1'b0;
      if (i == 6) mr_ni = 1'b1;
      if (i == 4 || i == 7 || i == 8) wdi_i = ~wdi_i;
      tick();
      if (rst_no) run++;
    end
    chk(run == 0, "R9 held during force", run, 0);
    ignore_i = 1'b0;
    wait_for(1'b1, 4 * P, idx);
    chk(idx == P, "R9 release point", idx, P);
    wait_for(1'b0, 4 * T, idx);
    chk(idx == T, "R9 next expiry", idx, T);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule